// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that a processor programs through a small register file of 16-bit words. Writes use a strobe, a word index and a data word, and reads return the selected word combinationally. Every control action (reload, resume, disable, status clear) takes effect only when the written data equals one exact 16-bit key. A write with any other value is dropped without side effects. The countdown advances once per `tick_i` pulse, which a slow-clock divider supplies at a 10 ms period. It starts from a 15-bit programmable timeout.

When one tick remains, the block sets an interrupt event, so software gets a last warning. When the count runs out, it asserts a system reset request for a fixed number of clocks and sets a sticky timed-out status. The status, the timeout value and the enable state sit in a power-on reset domain (`por_ni`). The rest of the block sits in the watchdog reset domain (`rst_ni`), which is the reset that the request triggers. After such a reset, software can still see why the chip restarted, and the timer resumes from the last programmed timeout. A debug-mode input stops the countdown unless software sets an override bit.

The word indices below are the byte offset divided by four.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset the timer is disabled, so index 3 reads 0xDABE. Index 4 reads 0x0000, index 1 reads the default timeout 6000, `rst_req_o` and `irq_o` are low, and the write-only indices 0, 2 and 7 read 0x0000.
- R2: Writing 0xFEED to index 0 reloads the count from the timeout register. Any other value written there leaves the count unchanged. A reload does not change the enable state.
- R3: While enabled, each `tick_i` pulse lowers the count by one. While disabled, ticks leave the count unchanged.
- R4: Writing 0x2BAD to index 2 and then, as the very next write, 0xCAFE to index 3 disables the timer, and index 3 then reads 0xDABE. The 0xCAFE write is ignored if it comes without that directly preceding key, or after a wrong key or any other intervening write. While the timer is enabled, index 3 reads 0x0000.
- R5: Writing 0xACED to index 7 enables the timer and reloads the count from the timeout register.
- R6: A tick that arrives while the count is 1 or 0 expires the timer. `rst_req_o` is then high for exactly RST_LEN clocks, starting with the clock edge that took the tick. Index 4 reads 0xCFE8, and when the request ends the count reloads from the timeout register.
- R7: A pulse on `rst_ni` alone keeps the status, the timeout and the enable state, and reloads the count from the timeout. On index 4, writing 0xE8B4 returns the status to 0x0000, and any other value leaves it unchanged.
- R8: Index 5 returns the count in bits 14:0. For one clock after the count changes, bit 15 reads 1 and the low bits still show the previous value. On the next read, bit 15 is 0 and the low bits show the new value.
- R9: The tick that takes the count from 2 to 1 sets the event flag, which is bit 0 of index 8. Writing 1 to that bit clears the flag by the next clock, and writing 0 leaves it set. `irq_o` equals the flag ANDed with bit 0 of index 9.
- R10: While bit 0 of index 10 is 1, the event flag is held set, and an acknowledge write does not clear it.
- R11: Bit 1 of index 6 reflects `dbg_mode_i`. While `dbg_mode_i` is high and bit 0 of index 6 is 0, ticks leave the count unchanged. With bit 0 set, counting proceeds.
- R12: The timeout register keeps bits 14:0 of a write to index 1, and reads back with bit 15 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous watchdog-domain reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the retained state |
| tick_i | input | 1 | One-clock pulse per 10 ms countdown step |
| dbg_mode_i | input | 1 | Chip is in debug mode |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 4 | Word index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| irq_o | output | 1 | Pre-expiry interrupt |
| rst_req_o | output | 1 | System reset request |

## Verification
The dangerous internal faults are ones that stay silent for a long time. A disable arm flag that is not cleared by an intervening write shows up only when a stray 0xCAFE write stops the timer and index 3 flips to 0xDABE. Retained state that is wrongly placed in the watchdog reset domain is seen only after a `rst_ni` pulse: index 4 drops back to 0x0000, or the count reloads from the default instead of the programmed value. A count decrement that is off by one makes the interrupt and the reset request fire one tick early or late, and this is visible within a single tick of the boundary. The stability flag on index 5 can be wrong for only one clock, so the bench reads it exactly in that clock.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int REG_W = 16;
  localparam int TO_W  = REG_W - 1;
  localparam int AW    = 4;

  localparam logic [AW-1:0] AD_FEED = 4'd0;
  localparam logic [AW-1:0] AD_TMO  = 4'd1;
  localparam logic [AW-1:0] AD_DIS1 = 4'd2;
  localparam logic [AW-1:0] AD_DIS2 = 4'd3;
  localparam logic [AW-1:0] AD_STAT = 4'd4;
  localparam logic [AW-1:0] AD_CNT  = 4'd5;
  localparam logic [AW-1:0] AD_DBG  = 4'd6;
  localparam logic [AW-1:0] AD_RSM  = 4'd7;
  localparam logic [AW-1:0] AD_EVT  = 4'd8;
  localparam logic [AW-1:0] AD_MSK  = 4'd9;
  localparam logic [AW-1:0] AD_FRC  = 4'd10;

  localparam logic [REG_W-1:0] K_FEED   = 16'hFEED;
  localparam logic [REG_W-1:0] K_DIS1   = 16'h2BAD;
  localparam logic [REG_W-1:0] K_DIS2   = 16'hCAFE;
  localparam logic [REG_W-1:0] K_RESUME = 16'hACED;
  localparam logic [REG_W-1:0] K_SCLR   = 16'hE8B4;
  localparam logic [REG_W-1:0] V_OFF    = 16'hDABE;
  localparam logic [REG_W-1:0] V_EXPD   = 16'hCFE8;

  typedef struct packed {
    logic feed;
    logic resume;
    logic dis;
    logic sclr;
    logic ack;
  } wdt_cmd_t;
endpackage

// File: rtl/wdt_keys.sv
`timescale 1ns/1ps
module wdt_keys
  import wdt_pkg::*;
#(
  parameter logic [TO_W-1:0] TO_DEF = 15'd6000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             expire_i,
  output wdt_cmd_t         cmd_o,
  output logic [TO_W-1:0]  tmo_o,
  output logic             en_o,
  output logic             stat_o,
  output logic             jovr_o,
  output logic             mask_o,
  output logic             force_o
);
  logic hit_feed, hit_tmo, hit_dis1, hit_dis2, hit_stat, hit_dbg, hit_rsm;
  logic hit_evt, hit_msk, hit_frc;
  logic arm_q, en_q, stat_q, jovr_q, mask_q, force_q;
  logic [TO_W-1:0] tmo_q;

  always_comb begin
    hit_feed = wr_en_i && (addr_i == AD_FEED);
    hit_tmo  = wr_en_i && (addr_i == AD_TMO);
    hit_dis1 = wr_en_i && (addr_i == AD_DIS1);
    hit_dis2 = wr_en_i && (addr_i == AD_DIS2);
    hit_stat = wr_en_i && (addr_i == AD_STAT);
    hit_dbg  = wr_en_i && (addr_i == AD_DBG);
    hit_rsm  = wr_en_i && (addr_i == AD_RSM);
    hit_evt  = wr_en_i && (addr_i == AD_EVT);
    hit_msk  = wr_en_i && (addr_i == AD_MSK);
    hit_frc  = wr_en_i && (addr_i == AD_FRC);
    cmd_o.feed   = hit_feed && (wdata_i == K_FEED);
    cmd_o.resume = hit_rsm  && (wdata_i == K_RESUME);
    cmd_o.dis    = hit_dis2 && (wdata_i == K_DIS2) && arm_q;
    cmd_o.sclr   = hit_stat && (wdata_i == K_SCLR);
    cmd_o.ack    = hit_evt  && wdata_i[0];
  end

  // retained across watchdog-triggered resets
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      tmo_q  <= TO_DEF;
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (hit_tmo) tmo_q <= wdata_i[TO_W-1:0];
      if (cmd_o.resume)   en_q <= 1'b1;
      else if (cmd_o.dis) en_q <= 1'b0;
      if (expire_i)        stat_q <= 1'b1;
      else if (cmd_o.sclr) stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= 1'b0;
      jovr_q  <= 1'b0;
      mask_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      // any write re-evaluates the arm, so only an adjacent pair disables
      if (wr_en_i) arm_q <= hit_dis1 && (wdata_i == K_DIS1);
      if (hit_dbg) jovr_q  <= wdata_i[0];
      if (hit_msk) mask_q  <= wdata_i[0];
      if (hit_frc) force_q <= wdata_i[0];
    end
  end

  assign tmo_o   = tmo_q;
  assign en_o    = en_q;
  assign stat_o  = stat_q;
  assign jovr_o  = jovr_q;
  assign mask_o  = mask_q;
  assign force_o = force_q;

  a_r4_dis_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $fell(en_q) |-> $past(wr_en_i && addr_i == AD_DIS2 && wdata_i == K_DIS2));
  a_r5_en_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(en_q) |-> $past(wr_en_i && addr_i == AD_RSM && wdata_i == K_RESUME));
  a_r6_stat_from_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(stat_q) |-> $past(expire_i));
  a_r7_stat_clear_keyed: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $fell(stat_q) |-> $past(wr_en_i && addr_i == AD_STAT && wdata_i == K_SCLR));
endmodule

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count
  import wdt_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            load_i,
  input  logic [TO_W-1:0] tmo_i,
  output logic [TO_W-1:0] cnt_o,
  output logic            unstable_o,
  output logic            pre_o,
  output logic            expire_o,
  output logic            rst_req_o
);
  localparam int RW = $clog2(RST_LEN + 1);

  logic [TO_W-1:0] cnt_q, shd_q;
  logic [RW-1:0]   rc_q;
  logic            ld_q, active;

  assign active   = run_i && !ld_q && (rc_q == '0) && !load_i;
  assign pre_o    = active && tick_i && (cnt_q == TO_W'(2));
  assign expire_o = active && tick_i && (cnt_q <= TO_W'(1));
  assign rst_req_o = (rc_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      shd_q <= '0;
      rc_q  <= '0;
      ld_q  <= 1'b1;
    end else begin
      shd_q <= cnt_q;
      if (ld_q) begin
        cnt_q <= tmo_i;
        ld_q  <= 1'b0;
      end else if (rc_q != '0) begin
        rc_q <= rc_q - RW'(1);
        if (rc_q == RW'(1)) cnt_q <= tmo_i;
      end else if (load_i) begin
        cnt_q <= tmo_i;
      end else if (expire_o) begin
        cnt_q <= '0;
        rc_q  <= RW'(RST_LEN);
      end else if (active && tick_i) begin
        cnt_q <= cnt_q - TO_W'(1);
      end
    end
  end

  // read side lags one clock; the flag marks that window
  assign cnt_o      = shd_q;
  assign unstable_o = (shd_q != cnt_q);

  a_r3_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i && !ld_q && rc_q == '0) |=> $stable(cnt_q));
  a_r6_req_from_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(tick_i && run_i));
  a_r8_flag_before_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != $past(cnt_o)) |-> $past(unstable_o));
  generate
    if (RST_LEN > 1) begin : g_len
      a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |=> rst_req_o);
    end
  endgenerate
endmodule

// File: rtl/wdt_irq.sv
`timescale 1ns/1ps
module wdt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pre_i,
  input  logic force_i,
  input  logic ack_i,
  input  logic mask_i,
  output logic evt_o,
  output logic irq_o
);
  logic evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               evt_q <= 1'b0;
    else if (pre_i || force_i) evt_q <= 1'b1;
    else if (ack_i)            evt_q <= 1'b0;
  end

  assign evt_o = evt_q;
  assign irq_o = evt_q && mask_i;

  a_r9_evt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q) |-> $past(pre_i || force_i));
  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !pre_i && !force_i) |=> !evt_q);
  a_r10_force_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> evt_q);
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter logic [TO_W-1:0] TO_DEF  = 15'd6000,
  parameter int              RST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             tick_i,
  input  logic             dbg_mode_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  wdt_cmd_t        cmd;
  logic [TO_W-1:0] tmo, cnt;
  logic en, stat, jovr, mask, frc, run, unstable, pre, expire, evt;

  assign run = en && (!dbg_mode_i || jovr);

  wdt_keys #(.TO_DEF(TO_DEF)) u_keys (
    .clk_i, .rst_ni, .por_ni, .wr_en_i, .addr_i, .wdata_i,
    .expire_i(expire), .cmd_o(cmd), .tmo_o(tmo), .en_o(en), .stat_o(stat),
    .jovr_o(jovr), .mask_o(mask), .force_o(frc)
  );

  wdt_count #(.RST_LEN(RST_LEN)) u_count (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .load_i(cmd.feed || cmd.resume),
    .tmo_i(tmo), .cnt_o(cnt), .unstable_o(unstable), .pre_o(pre),
    .expire_o(expire), .rst_req_o
  );

  wdt_irq u_irq (
    .clk_i, .rst_ni, .pre_i(pre), .force_i(frc), .ack_i(cmd.ack),
    .mask_i(mask), .evt_o(evt), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AD_TMO:  rdata_o = {1'b0, tmo};
      AD_DIS2: rdata_o = en ? '0 : V_OFF;
      AD_STAT: rdata_o = stat ? V_EXPD : '0;
      AD_CNT:  rdata_o = {unstable, cnt};
      AD_DBG:  rdata_o = {{(REG_W-2){1'b0}}, dbg_mode_i, jovr};
      AD_EVT:  rdata_o = {{(REG_W-1){1'b0}}, evt};
      AD_MSK:  rdata_o = {{(REG_W-1){1'b0}}, mask};
      AD_FRC:  rdata_o = {{(REG_W-1){1'b0}}, frc};
      default: rdata_o = '0;
    endcase
  end

  a_r6_status_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(rst_req_o) |-> stat);
  a_r11_debug_halts: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (dbg_mode_i && !jovr) |-> !expire);
endmodule

// File: tb/tb_wdt_keyed.sv
`timescale 1ns/1ps
module tb_wdt_keyed;
  import wdt_pkg::*;
  localparam int RST_LEN = 4;
  localparam logic [14:0] TO_DEF = 15'd6000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, por_n = 1'b0, tick = 1'b0, dbg = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, rst_req;

  wdt_keyed #(.TO_DEF(TO_DEF), .RST_LEN(RST_LEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick), .dbg_mode_i(dbg),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model of the programmed state
  logic m_en, m_stat, m_evt, m_mask, m_force, m_jovr, m_k1;
  logic [14:0] m_to, m_cnt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
    case (a)
      AD_FEED: if (d == K_FEED) m_cnt = m_to;
      AD_TMO:  m_to = d[14:0];
      AD_DIS2: if (d == K_DIS2 && m_k1) m_en = 1'b0;
      AD_STAT: if (d == K_SCLR) m_stat = 1'b0;
      AD_DBG:  m_jovr = d[0];
      AD_RSM:  if (d == K_RESUME) begin m_en = 1'b1; m_cnt = m_to; end
      AD_EVT:  if (d[0] && !m_force) m_evt = 1'b0;
      AD_MSK:  m_mask = d[0];
      AD_FRC:  begin m_force = d[0]; if (d[0]) m_evt = 1'b1; end
      default: ;
    endcase
    m_k1 = (a == AD_DIS1) && (d == K_DIS1);
  endfunction

  function automatic void model_tick();
    if (m_en && (!dbg || m_jovr)) begin
      if (m_cnt <= 15'd1) begin
        m_stat = 1'b1;
        m_cnt  = m_to;
      end else begin
        if (m_cnt == 15'd2) m_evt = 1'b1;
        m_cnt = m_cnt - 15'd1;
      end
    end
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    model_tick();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [15:0] v;
    idle(RST_LEN + 2);
    rd(AD_CNT, v);  chk({tag, " R8 count"}, v, {1'b0, m_cnt});
    rd(AD_DIS2, v); chk({tag, " R4 enable state"}, v, m_en ? 16'h0000 : V_OFF);
    rd(AD_STAT, v); chk({tag, " R6 status"}, v, m_stat ? V_EXPD : 16'h0000);
    rd(AD_EVT, v);  chk({tag, " R9 event"}, v, {15'b0, m_evt});
    chk({tag, " R9 irq"}, irq, m_evt && m_mask);
    chk({tag, " R6 no request"}, rst_req, 1'b0);
  endtask

  initial begin
    logic [15:0] v;
    int hi;
    m_en = 0; m_stat = 0; m_evt = 0; m_mask = 0; m_force = 0; m_jovr = 0; m_k1 = 0;
    m_to = TO_DEF; m_cnt = TO_DEF;
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    idle(3);
    // R1 reset state
    rd(AD_DIS2, v); chk("R1 disabled after power-on", v, V_OFF);
    rd(AD_STAT, v); chk("R1 status normal", v, 16'h0000);
    rd(AD_TMO, v);  chk("R1 default timeout", v, {1'b0, TO_DEF});
    rd(AD_FEED, v); chk("R1 write-only reads zero", v, 16'h0000);
    rd(AD_RSM, v);  chk("R1 write-only reads zero", v, 16'h0000);
    chk("R1 no request", rst_req, 1'b0);
    chk("R1 no irq", irq, 1'b0);
    check_all("R1");

    // R3 disabled timer ignores ticks; R2 bad feed key ignored
    tick1(); tick1(); check_all("R3 disabled");
    wr(AD_TMO, 16'd10);
    wr(AD_FEED, 16'hFEEE); check_all("R2 bad feed key");
    wr(AD_FEED, K_FEED);   check_all("R2 feed reload");
    tick1(); check_all("R2 feed keeps disabled");
    // R5 resume
    wr(AD_RSM, 16'hACEE); check_all("R5 bad resume key");
    wr(AD_RSM, K_RESUME); check_all("R5 resume");
    tick1(); tick1(); tick1(); check_all("R3 counting");
    // R8 stability flag window
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd(AD_CNT, v); chk("R8 unstable window", v, {1'b1, 15'd7});
    @(negedge clk);
    rd(AD_CNT, v); chk("R8 stable value", v, {1'b0, 15'd6});
    model_tick();

    // R12 timeout width
    wr(AD_TMO, 16'hFFFF);
    rd(AD_TMO, v); chk("R12 timeout 15 bits", v, 16'h7FFF);
    wr(AD_TMO, 16'd5);

    // R9 pre-expiry event
    wr(AD_FEED, K_FEED);
    tick1(); tick1(); tick1(); check_all("R9 before event");
    tick1(); check_all("R9 event set");
    wr(AD_EVT, 16'h0000); check_all("R9 zero ack ignored");
    wr(AD_MSK, 16'h0001); check_all("R9 irq unmasked");
    wr(AD_EVT, 16'h0001);
    rd(AD_EVT, v); chk("R9 ack next clock", v, 16'h0000);
    chk("R9 irq drops", irq, 1'b0);

    // R6 expiry and reset request length
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    hi = 0;
    for (int i = 0; i < RST_LEN + 3; i++) begin
      if (rst_req) hi++;
      @(negedge clk);
    end
    chk("R6 request length", hi, RST_LEN);
    model_tick();
    check_all("R6 after expiry");

    // R7 watchdog-domain reset keeps retained state
    rst_n = 1'b0; idle(3); rst_n = 1'b1;
    m_evt = 0; m_mask = 0; m_force = 0; m_jovr = 0; m_k1 = 0; m_cnt = m_to;
    check_all("R7 after reset");
    rd(AD_TMO, v); chk("R7 timeout kept", v, 16'd5);
    wr(AD_STAT, 16'h1234); check_all("R7 bad clear key");
    wr(AD_STAT, K_SCLR);   check_all("R7 status cleared");

    // R4 disable sequence
    wr(AD_DIS1, K_DIS1); wr(AD_TMO, 16'd5); wr(AD_DIS2, K_DIS2);
    check_all("R4 intervening write");
    wr(AD_DIS2, K_DIS2); check_all("R4 second key alone");
    wr(AD_DIS1, 16'h2BAE); wr(AD_DIS2, K_DIS2); check_all("R4 wrong first key");
    wr(AD_DIS1, K_DIS1); wr(AD_DIS2, 16'hCAFF); check_all("R4 wrong second key");
    wr(AD_DIS1, K_DIS1); wr(AD_DIS2, K_DIS2); check_all("R4 disabled");
    tick1(); check_all("R4 disabled holds");
    wr(AD_RSM, K_RESUME);

    // R11 debug hold
    dbg = 1'b1;
    rd(AD_DBG, v); chk("R11 debug flag", v, 16'h0002);
    tick1(); check_all("R11 held in debug");
    wr(AD_DBG, 16'h0001);
    rd(AD_DBG, v); chk("R11 override set", v, 16'h0003);
    tick1(); check_all("R11 override counts");
    dbg = 1'b0; wr(AD_DBG, 16'h0000);

    // R10 force
    wr(AD_FRC, 16'h0001); check_all("R10 force sets");
    wr(AD_EVT, 16'h0001); check_all("R10 ack under force");
    wr(AD_FRC, 16'h0000); wr(AD_EVT, 16'h0001); check_all("R10 released");

    // constrained random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 11);
      case (op)
        0, 1, 2, 3: tick1();
        4: wr(AD_FEED, K_FEED);
        5: wr(AD_FEED, 16'($urandom));
        6: wr(AD_TMO, 16'($urandom_range(0, 12)));
        7: begin wr(AD_DIS1, K_DIS1); wr(AD_DIS2, K_DIS2); end
        8: wr(($urandom_range(0, 1) == 0) ? AD_DIS1 : AD_DIS2, 16'($urandom));
        9: wr(AD_RSM, K_RESUME);
        10: wr(AD_EVT, 16'($urandom_range(0, 1)));
        default: wr(($urandom_range(0, 1) == 0) ? AD_MSK : AD_FRC, 16'($urandom_range(0, 1)));
      endcase
      check_all("R2 R3 R4 R6 R9 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1-run: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule